// File: doc/BRIEF.md
# I2C Target Byte Engine with Transmit Clock Hold

This block is the target side of a two-wire serial bus. It watches the clock and data lines, picks out START and STOP conditions, and compares the first byte of each transfer with its own 7-bit address. When the address matches, it moves bytes in either direction. Both bus pins are open-drain: the block never drives a line high. It only asserts an enable that pulls the line low. The bus inputs reach the logic through a synchroniser chain.

The local processor works through a small set of signals:
- a shared data buffer, which it loads with `cpu_wr` and reads with `cpu_rd`;
- flags for buffer full and overflow;
- a flag that tells a data byte from an address byte;
- a direction and acknowledge status bit;
- a sticky interrupt flag;
- a clock-release strobe.

On a read transfer the engine holds SCL low before each byte it has to send. It keeps the clock held until the processor has loaded the buffer and then asked for the release. The direction status bit is reused after each sent byte to record whether the master acknowledged that byte.

Top module: `iic_slave_stretch`

## Requirements
- R1: After reset both line enables are low, and the flags irq, buf_full, ovf, is_data and rw_stat are all 0.
- R2: An address byte whose upper 7 bits equal OWN_ADDR and whose bit 0 (R/W) is 1 is acknowledged: sda_oe is high through the ninth clock. After that clock the engine sets scl_oe and irq, with rw_stat = 1 and is_data = 0.
- R3: An address byte that does not match gets no acknowledge. irq, scl_oe and sda_oe stay low for the rest of that transfer.
- R4: While SCL is held, a rel_req pulse has no effect unless cpu_wr has loaded the buffer since the hold began.
- R5: A granted release drops scl_oe and at the same time sets sda_oe to the inverse of bit 7 of the loaded byte. The byte is then sent MSB first.
- R6: If the master acknowledges a sent byte (SDA low on the ninth clock), the engine holds SCL again and sets irq, with rw_stat = 1 and is_data = 1.
- R7: If the master does not acknowledge a sent byte, the engine neither holds SCL nor raises irq. It sets rw_stat to 0 and drives nothing until the next START and matching address.
- R8: A matching address with R/W = 0 is acknowledged, loaded into the buffer, and sets buf_full and irq with is_data = 0 and rw_stat = 0. Each later data byte is acknowledged, stored, and sets buf_full, irq and is_data = 1. A cpu_rd pulse clears buf_full.
- R9: A data byte that arrives while buf_full is 1 sets ovf and is not acknowledged. The buffer keeps its old contents. A cpu_rd pulse clears ovf.
- R10: irq stays at 1 until an irq_clr pulse.
- R11: A STOP or a repeated START in any state releases both lines and restarts address matching.
- R12: The engine changes sda_oe only while SCL is low, so SDA is stable whenever SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cpu_wr | input | 1 | Load cpu_wdata into the buffer and arm the clock release |
| cpu_wdata | input | AW+1 | Byte to be sent |
| cpu_rd | input | 1 | Buffer-read strobe; clears buf_full and ovf |
| cpu_rdata | output | AW+1 | Buffer contents |
| rel_req | input | 1 | Clock-release request |
| irq_clr | input | 1 | Clears irq |
| irq | output | 1 | Sticky interrupt flag |
| buf_full | output | 1 | Received byte is waiting |
| ovf | output | 1 | A byte arrived while the buffer was full |
| is_data | output | 1 | 1: the last byte was data, 0: it was an address |
| rw_stat | output | 1 | R/W of the address, then the ACK (1) or NACK (0) of the last sent byte |

## Verification
A wrong state in the engine usually shows up on the bus within one bit time. It appears as a missing or extra low on SDA during an acknowledge clock, or as a clock hold that never ends or never starts. A hold that never ends stalls the master at once. A bad shift count or bit order shows as a miscompared byte at the end of the same byte. A wrong flag such as rw_stat, is_data or ovf stays invisible on the bus. It only shows at the status outputs when the processor samples them after the acknowledge clock. For that reason those outputs are compared right after every acknowledge.

// File: rtl/iic_stretch_pkg.sv
package iic_stretch_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RECV,
      ST_RACK,
      ST_HOLD,
      ST_SEND,
      ST_SACK
   } eng_state_t;
endpackage

// File: rtl/iic_sync.sv
module iic_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] pipe [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[g] <= '1;
            else        pipe[g] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[g] <= '1;
            else        pipe[g] <= pipe[g-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/iic_bus_events.sv
module iic_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_p,
   output logic stop_p,
   output logic rise_p,
   output logic fall_p
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end

   // SDA edges while SCL stays high mark bus conditions
   assign start_p = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_p  = scl_s & scl_d & ~sda_d & sda_s;
   assign rise_p  = scl_s & ~scl_d;
   assign fall_p  = ~scl_s & scl_d;
endmodule

// File: rtl/iic_byte_engine.sv
module iic_byte_engine
   import iic_stretch_pkg::*;
#(
   parameter int             AW       = 7,
   parameter logic [AW-1:0]  OWN_ADDR = '0,
   localparam int            DW       = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_p,
   input  logic          stop_p,
   input  logic          rise_p,
   input  logic          fall_p,
   input  logic          sda_s,
   input  logic          cpu_wr,
   input  logic [DW-1:0] cpu_wdata,
   input  logic          cpu_rd,
   input  logic          rel_req,
   input  logic          irq_clr,
   output logic          scl_oe,
   output logic          sda_oe,
   output logic [DW-1:0] dbuf,
   output logic          irq,
   output logic          buf_full,
   output logic          ovf,
   output logic          is_data,
   output logic          rw_stat,
   output logic          tx_armed
);
   localparam int            CW        = $clog2(DW + 1);
   localparam logic [CW-1:0] CNT_FULL  = CW'(DW);
   localparam logic [CW-1:0] CNT_LAST  = CW'(DW - 1);

   eng_state_t    state;
   logic [DW-1:0] shreg;
   logic [CW-1:0] cnt;
   logic          is_addr, dir_rd, ack_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         cnt      <= '0;
         is_addr  <= 1'b0;
         dir_rd   <= 1'b0;
         ack_seen <= 1'b0;
         dbuf     <= '0;
         irq      <= 1'b0;
         buf_full <= 1'b0;
         ovf      <= 1'b0;
         is_data  <= 1'b0;
         rw_stat  <= 1'b0;
         tx_armed <= 1'b0;
         scl_oe   <= 1'b0;
         sda_oe   <= 1'b0;
      end else begin
         // processor side; engine updates below take precedence
         if (cpu_rd) begin
            buf_full <= 1'b0;
            ovf      <= 1'b0;
         end
         if (irq_clr) irq <= 1'b0;
         if (cpu_wr) begin
            dbuf     <= cpu_wdata;
            tx_armed <= 1'b1;
         end

         if (start_p || stop_p) begin
            state   <= start_p ? ST_RECV : ST_IDLE;
            cnt     <= '0;
            is_addr <= 1'b1;
            dir_rd  <= 1'b0;
            rw_stat <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_RECV: begin
                  if (rise_p && cnt != CNT_FULL) begin
                     shreg <= {shreg[DW-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (fall_p && cnt == CNT_FULL) begin
                     cnt <= '0;
                     if (is_addr) begin
                        if (shreg[DW-1:1] == OWN_ADDR) begin
                           state   <= ST_RACK;
                           sda_oe  <= 1'b1;
                           dir_rd  <= shreg[0];
                           rw_stat <= shreg[0];
                           is_data <= 1'b0;
                           if (!shreg[0]) begin
                              dbuf     <= shreg;
                              buf_full <= 1'b1;
                              irq      <= 1'b1;
                           end
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        state   <= ST_RACK;
                        is_data <= 1'b1;
                        if (buf_full) begin
                           ovf <= 1'b1;
                        end else begin
                           dbuf     <= shreg;
                           buf_full <= 1'b1;
                           irq      <= 1'b1;
                           sda_oe   <= 1'b1;
                        end
                     end
                  end
               end
               ST_RACK: begin
                  if (fall_p) begin
                     sda_oe  <= 1'b0;
                     is_addr <= 1'b0;
                     if (dir_rd) begin
                        state    <= ST_HOLD;
                        scl_oe   <= 1'b1;
                        irq      <= 1'b1;
                        tx_armed <= 1'b0;
                     end else begin
                        state <= ST_RECV;
                     end
                  end
               end
               ST_HOLD: begin
                  if (rel_req && tx_armed) begin
                     state    <= ST_SEND;
                     scl_oe   <= 1'b0;
                     shreg    <= dbuf;
                     sda_oe   <= ~dbuf[DW-1];
                     cnt      <= '0;
                     tx_armed <= 1'b0;
                  end
               end
               ST_SEND: begin
                  if (fall_p) begin
                     if (cnt == CNT_LAST) begin
                        state  <= ST_SACK;
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                     end else begin
                        shreg  <= {shreg[DW-2:0], 1'b0};
                        sda_oe <= ~shreg[DW-2];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               ST_SACK: begin
                  if (rise_p) begin
                     ack_seen <= ~sda_s;
                     rw_stat  <= ~sda_s;
                  end else if (fall_p) begin
                     if (ack_seen) begin
                        state    <= ST_HOLD;
                        scl_oe   <= 1'b1;
                        irq      <= 1'b1;
                        is_data  <= 1'b1;
                        tx_armed <= 1'b0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/iic_slave_stretch.sv
module iic_slave_stretch #(
   parameter int            AW          = 7,
   parameter logic [AW-1:0] OWN_ADDR    = 7'h3A,
   parameter int            SYNC_STAGES = 2,
   localparam int           DW          = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          scl_oe,
   output logic          sda_oe,
   input  logic          cpu_wr,
   input  logic [DW-1:0] cpu_wdata,
   input  logic          cpu_rd,
   output logic [DW-1:0] cpu_rdata,
   input  logic          rel_req,
   input  logic          irq_clr,
   output logic          irq,
   output logic          buf_full,
   output logic          ovf,
   output logic          is_data,
   output logic          rw_stat
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("AW must be at least 2");
   end

   logic [1:0] bus_s;
   logic       scl_s, sda_s;
   logic       start_p, stop_p, rise_p, fall_p;
   logic       tx_armed;

   iic_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
   );
   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   iic_bus_events u_evt (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .start_p(start_p), .stop_p(stop_p), .rise_p(rise_p), .fall_p(fall_p)
   );

   iic_byte_engine #(.AW(AW), .OWN_ADDR(OWN_ADDR)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .start_p(start_p), .stop_p(stop_p), .rise_p(rise_p), .fall_p(fall_p),
      .sda_s(sda_s),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
      .rel_req(rel_req), .irq_clr(irq_clr),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .dbuf(cpu_rdata),
      .irq(irq), .buf_full(buf_full), .ovf(ovf),
      .is_data(is_data), .rw_stat(rw_stat), .tx_armed(tx_armed)
   );
endmodule

// File: rtl/iic_stretch_chk.sv
module iic_stretch_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic stop_p,
   input logic scl_oe,
   input logic sda_oe,
   input logic rel_req,
   input logic tx_armed,
   input logic irq,
   input logic irq_clr,
   input logic ovf,
   input logic buf_full
);
   // R4
   a_r4_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe && rel_req && !tx_armed) |=> scl_oe);

   // R10
   a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   // R9
   a_r9_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(buf_full));

   // R11
   a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> (!scl_oe && !sda_oe));

   // R2 and R6
   a_r2_hold_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> irq);

   // R12
   a_r12_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
endmodule

bind iic_slave_stretch iic_stretch_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_p(stop_p),
   .scl_oe(scl_oe), .sda_oe(sda_oe), .rel_req(rel_req),
   .tx_armed(tx_armed), .irq(irq), .irq_clr(irq_clr),
   .ovf(ovf), .buf_full(buf_full)
);

// File: tb/sim_iic_slave_stretch.sv
`timescale 1ns/1ps
module sim_iic_slave_stretch;
   localparam logic [6:0] ME    = 7'h3A;
   localparam logic [6:0] OTHER = 7'h51;
   localparam int         Q     = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       scl_oe, sda_oe;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0, rel_req = 1'b0, irq_clr = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       irq, buf_full, ovf, is_data, rw_stat;
   wire        scl_line = scl_m & ~scl_oe;
   wire        sda_line = sda_m & ~sda_oe;

   int  n_chk = 0, n_bad = 0;
   bit  done = 1'b0;

   iic_slave_stretch #(.OWN_ADDR(ME)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
      .cpu_rdata(cpu_rdata), .rel_req(rel_req), .irq_clr(irq_clr),
      .irq(irq), .buf_full(buf_full), .ovf(ovf),
      .is_data(is_data), .rw_stat(rw_stat)
   );

   function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
      return {a, rd};
   endfunction

   function automatic logic exp_first_drive(input logic [7:0] b);
      return ~b[7];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_high();
      int g = 0;
      scl_m = 1'b1;
      while (scl_line !== 1'b1 && g < 4000) begin
         @(negedge clk);
         g++;
      end
      if (g >= 4000) chk("R4 scl held", 32'(scl_line), 32'd1);
   endtask

   task automatic m_start();
      sda_m = 1'b1; tick(Q);
      wait_high(); tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic m_stop();
      sda_m = 1'b0; tick(Q);
      wait_high(); tick(Q);
      sda_m = 1'b1; tick(2*Q);
   endtask

   task automatic m_bit_w(input logic b);
      sda_m = b; tick(Q);
      wait_high(); tick(2*Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic m_bit_r(output logic b);
      sda_m = 1'b1; tick(Q);
      wait_high(); tick(Q);
      b = sda_line;
      tick(Q);
      chk("R12 sda stable while scl high", 32'(sda_line), 32'(b));
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic m_send(input logic [7:0] b, output logic ack_n);
      for (int i = 7; i >= 0; i--) m_bit_w(b[i]);
      m_bit_r(ack_n);
   endtask

   task automatic m_recv(output logic [7:0] b, input logic nack);
      for (int i = 7; i >= 0; i--) m_bit_r(b[i]);
      m_bit_w(nack);
   endtask

   task automatic pulse_wr(input logic [7:0] b);
      cpu_wdata = b; cpu_wr = 1'b1; tick(1); cpu_wr = 1'b0; tick(2);
   endtask
   task automatic pulse_rel();
      rel_req = 1'b1; tick(1); rel_req = 1'b0; tick(2);
   endtask
   task automatic pulse_rd();
      cpu_rd = 1'b1; tick(1); cpu_rd = 1'b0; tick(2);
   endtask
   task automatic pulse_clr();
      irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic       a;
      logic [7:0] got;
      void'($urandom(32'd2024));
      tick(5); rst_n = 1'b1; tick(5);

      // R1 reset state
      chk("R1 reset outputs", {27'd0, scl_oe, sda_oe, irq, buf_full, ovf}, 32'd0);
      chk("R1 reset status", {30'd0, is_data, rw_stat}, 32'd0);

      // R3 address mismatch
      m_start();
      m_send(addr_byte(OTHER, 1'b1), a);
      chk("R3 no ack", 32'(a), 32'd1);
      chk("R3 no hold no irq", {30'd0, scl_oe, irq}, 32'd0);
      m_bit_r(a);
      chk("R3 sda untouched", {31'd0, sda_oe}, 32'd0);
      m_stop();

      // R2 read address
      m_start();
      m_send(addr_byte(ME, 1'b1), a);
      chk("R2 ack", 32'(a), 32'd0);
      chk("R2 hold irq rw isdata", {28'd0, scl_oe, irq, rw_stat, is_data}, 32'b1110);
      tick(30);
      chk("R10 irq sticky", 32'(irq), 32'd1);
      pulse_clr();
      chk("R10 irq cleared", 32'(irq), 32'd0);
      // R4 release without load
      pulse_rel(); tick(20);
      chk("R4 release ignored", 32'(scl_oe), 32'd1);
      pulse_wr(8'h5A);
      chk("R4 load alone keeps hold", 32'(scl_oe), 32'd1);
      pulse_rel();
      chk("R5 msb on release", {30'd0, scl_oe, sda_oe}, {30'd0, 1'b0, exp_first_drive(8'h5A)});
      m_recv(got, 1'b0);
      chk("R5 byte msb first", 32'(got), 32'h5A);
      chk("R6 ack re-hold", {28'd0, scl_oe, irq, rw_stat, is_data}, 32'b1111);
      pulse_clr();
      pulse_wr(8'hC3); pulse_rel();
      m_recv(got, 1'b1);
      chk("R5 second byte", 32'(got), 32'hC3);
      tick(4);
      chk("R7 nack no hold irq rw", {29'd0, scl_oe, irq, rw_stat}, 32'd0);
      m_recv(got, 1'b1);
      chk("R7 idle after nack", 32'(got), 32'hFF);
      m_stop();

      // R8 write path
      m_start();
      m_send(addr_byte(ME, 1'b0), a);
      chk("R8 write addr ack", 32'(a), 32'd0);
      chk("R8 addr flags", {28'd0, irq, buf_full, is_data, rw_stat}, 32'b1100);
      chk("R8 addr in buffer", 32'(cpu_rdata), 32'(addr_byte(ME, 1'b0)));
      pulse_clr(); pulse_rd();
      chk("R8 read clears full", 32'(buf_full), 32'd0);
      m_send(8'h3C, a);
      chk("R8 data ack", 32'(a), 32'd0);
      chk("R8 data stored", {21'd0, irq, buf_full, is_data, cpu_rdata}, {21'd0, 3'b111, 8'h3C});
      pulse_clr();
      m_send(8'h99, a);
      chk("R9 overflow nack", 32'(a), 32'd1);
      chk("R9 ovf keeps old", {23'd0, ovf, cpu_rdata}, {23'd0, 1'b1, 8'h3C});
      pulse_rd();
      chk("R9 read clears ovf", {30'd0, ovf, buf_full}, 32'd0);
      m_send(8'h7E, a);
      chk("R8 after overflow", {23'd0, a, cpu_rdata}, {23'd0, 1'b0, 8'h7E});
      pulse_rd(); pulse_clr();
      // R11 repeated START mid byte
      m_bit_w(1'b0); m_bit_w(1'b1); m_bit_w(1'b0);
      m_start();
      chk("R11 rstart releases", {30'd0, scl_oe, sda_oe}, 32'd0);
      m_send(addr_byte(ME, 1'b1), a);
      chk("R11 new address ok", {30'd0, a, scl_oe}, 32'b01);
      pulse_clr(); pulse_wr(8'hFF); pulse_rel();
      m_recv(got, 1'b1);
      // R11 STOP mid byte
      m_stop();
      m_start();
      m_send(addr_byte(ME, 1'b0), a);
      pulse_rd(); pulse_clr();
      m_bit_w(1'b0); m_bit_w(1'b0);
      m_stop();
      chk("R11 stop releases", {30'd0, scl_oe, sda_oe}, 32'd0);

      // random transfers
      for (int t = 0; t < 12; t++) begin
         automatic logic rd = 1'($urandom % 2);
         automatic int   n  = 1 + int'($urandom % 3);
         m_start();
         m_send(addr_byte(ME, rd), a);
         chk(rd ? "R2 random ack" : "R8 random ack", 32'(a), 32'd0);
         pulse_clr();
         if (!rd) pulse_rd();
         for (int k = 0; k < n; k++) begin
            automatic logic [7:0] b = 8'($urandom);
            if (rd) begin
               pulse_wr(b); pulse_rel();
               m_recv(got, (k == n - 1));
               chk("R5 random byte", 32'(got), 32'(b));
               if (k != n - 1) begin
                  chk("R6 random re-hold", {30'd0, scl_oe, irq}, 32'b11);
                  pulse_clr();
               end else begin
                  tick(4);
                  chk("R7 random release", {30'd0, scl_oe, irq}, 32'd0);
               end
            end else begin
               m_send(b, a);
               chk("R8 random data", {23'd0, a, cpu_rdata}, {23'd0, 1'b0, b});
               pulse_rd(); pulse_clr();
            end
         end
         m_stop();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule